// File: doc/BRIEF.md
# Converter Status and Request Unit

This block holds the status and request logic that sits beside an analog-to-digital converter's register file. Completion pulses from the converter side (a per-sample done, an averaging-run done, an overrun, a window match and a synchronization done) arrive as single-cycle inputs. The unit keeps one sticky flag per condition, an enable mask written through separate set and clear addresses, and a combined interrupt request line. It also holds the latest conversion result behind a DMA request that stays up until that result is read.

Two of the conditions, result ready and window match, can also leave the block as event pulses, each gated by its own enable bit. Two incoming event strobes, start-conversion and flush, are turned into one-cycle control pulses for the converter. They touch no flag, no interrupt and no DMA state.

A simple register bus gives access to the unit. A write completes in the cycle that select and write are high. Read data is combinational from the address while select is high and write is low.

Top module: `cvt_req_unit`

## Requirements
- R1: A condition pulse sets its flag, visible at flag register address 0 one cycle later. The bit positions are bit0 result ready, bit1 overrun, bit2 window match and bit3 synchronization done.
- R2: Writing a one to a bit at address 0 clears that flag, and writing a zero leaves it unchanged. When a condition pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R3: A one written at address 1 sets that enable bit, and a one written at address 2 clears it. Zeros written to either address change nothing. Reading either address returns the current enable mask.
- R4: `irq_o` is high whenever some flag and its enable bit are both one. It falls only when such flags are cleared or disabled, or on reset.
- R5: `dma_req_o` rises one cycle after a result-ready condition. A read of address 4 returns the captured result and drops `dma_req_o` at the next edge. If a new result-ready condition arrives in the same cycle as that read, the read returns the old value and the request stays high.
- R6: With `avg_mode_i` high, only `avg_done_i` counts as result ready and `smp_done_i` is ignored. With `avg_mode_i` low, only `smp_done_i` counts and `avg_done_i` is ignored.
- R7: The overrun flag is set by `ovr_i`. It is also set by a result-ready condition that arrives while `dma_req_o` is high and no result read happens in that cycle.
- R8: `evout_rdy_o` pulses in the same cycle as a result-ready condition if bit0 of the event control register (address 3) is one. `evout_win_o` pulses in the same cycle as `win_i` if bit1 is one. Address 3 reads back both bits.
- R9: `start_pulse_o` and `flush_pulse_o` are high for exactly one cycle, starting one cycle after the rising edge of `evin_start_i` or `evin_flush_i`. These strobes change no flag, no DMA request and no interrupt.
- R10: After reset, all flags, enables, event control bits, the DMA request, the interrupt and the output pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_done_i | input | 1 | Single-sample conversion done pulse |
| avg_done_i | input | 1 | Averaging run done pulse |
| avg_mode_i | input | 1 | Averaging mode selected |
| res_data_i | input | RES_W | Result value presented with the done pulse |
| ovr_i | input | 1 | External overrun condition pulse |
| win_i | input | 1 | Window match pulse |
| syn_i | input | 1 | Synchronization done pulse |
| evin_start_i | input | 1 | Incoming start-conversion event strobe |
| evin_flush_i | input | 1 | Incoming flush event strobe |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write (1) or read (0) |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data |
| irq_o | output | 1 | Combined interrupt request |
| dma_req_o | output | 1 | Result-pending DMA request |
| evout_rdy_o | output | 1 | Result-ready event pulse |
| evout_win_o | output | 1 | Window-match event pulse |
| start_pulse_o | output | 1 | Start-conversion control pulse |
| flush_pulse_o | output | 1 | Flush control pulse |

## Verification
Several pairs of functions can fall in the same cycle. A hardware set and a software clear can hit one flag, and a new result can arrive while the previous one is being read. The bench provokes the first pair by pulsing `syn_i` while writing a one to bit3 of the flag register, and judges it by reading the flag back as set. It provokes the second pair by raising `smp_done_i` during a read of address 4. That read must return the old value, leave `dma_req_o` high and leave the overrun flag clear.

// File: rtl/cvt_req_pkg.sv
package cvt_req_pkg;

  localparam int NSRC    = 4;
  localparam int SRC_RDY = 0;
  localparam int SRC_OVR = 1;
  localparam int SRC_WIN = 2;
  localparam int SRC_SYN = 3;

  localparam int NEVO    = 2;
  localparam int EVO_RDY = 0;
  localparam int EVO_WIN = 1;

  localparam int REG_FLAG   = 0;
  localparam int REG_ENSET  = 1;
  localparam int REG_ENCLR  = 2;
  localparam int REG_EVCFG  = 3;
  localparam int REG_RESULT = 4;

  // sticky flag update: a hardware set takes priority over a write-one clear
  function automatic logic [NSRC-1:0] flag_next(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] set,
    input logic [NSRC-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  // enable mask update from the set and clear addresses
  function automatic logic [NSRC-1:0] mask_next(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] set,
    input logic [NSRC-1:0] clr
  );
    return (cur | set) & ~clr;
  endfunction

  // pending request: a new result keeps it up even against a read
  function automatic logic pend_next(
    input logic cur,
    input logic raise,
    input logic drop
  );
    return raise | (cur & ~drop);
  endfunction

endpackage

// File: rtl/cvt_flag_bank.sv
module cvt_flag_bank
  import cvt_req_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);

  logic [N-1:0] flag_q;
  logic [N-1:0] en_q;
  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
        en_q[i]   <= (en_q[i] | en_set_i[i]) & ~en_clr_i[i];
      end
    end
    assign live[i] = flag_q[i] & en_q[i];
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = |live;

endmodule

// File: rtl/cvt_result_path.sv
module cvt_result_path
  import cvt_req_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_done_i,
  input  logic             avg_done_i,
  input  logic             avg_mode_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic             res_rd_i,
  output logic             rdy_evt_o,
  output logic             lost_o,
  output logic             dma_o,
  output logic [RES_W-1:0] result_o
);

  logic             dma_q;
  logic [RES_W-1:0] res_q;
  logic             rdy;

  // in averaging mode only the end of the run counts as a result
  assign rdy = avg_mode_i ? avg_done_i : smp_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= 1'b0;
      res_q <= '0;
    end else begin
      dma_q <= pend_next(dma_q, rdy, res_rd_i);
      if (rdy) res_q <= res_data_i;
    end
  end

  // previous result still pending and not being taken now
  assign lost_o    = rdy & dma_q & ~res_rd_i;
  assign rdy_evt_o = rdy;
  assign dma_o     = dma_q;
  assign result_o  = res_q;

endmodule

// File: rtl/cvt_evt_gate.sv
module cvt_evt_gate
  import cvt_req_pkg::*;
#(
  parameter int NIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rdy_evt_i,
  input  logic            win_i,
  input  logic [NEVO-1:0] cfg_i,
  input  logic [NIN-1:0]  strobe_i,
  output logic            evout_rdy_o,
  output logic            evout_win_o,
  output logic [NIN-1:0]  pulse_o
);

  logic [NIN-1:0] prev_q;
  logic [NIN-1:0] pulse_q;

  assign evout_rdy_o = rdy_evt_i & cfg_i[EVO_RDY];
  assign evout_win_o = win_i & cfg_i[EVO_WIN];

  for (genvar k = 0; k < NIN; k++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[k]  <= 1'b0;
        pulse_q[k] <= 1'b0;
      end else begin
        prev_q[k]  <= strobe_i[k];
        pulse_q[k] <= strobe_i[k] & ~prev_q[k];
      end
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/cvt_req_unit.sv
module cvt_req_unit
  import cvt_req_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_done_i,
  input  logic              avg_done_i,
  input  logic              avg_mode_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              ovr_i,
  input  logic              win_i,
  input  logic              syn_i,
  input  logic              evin_start_i,
  input  logic              evin_flush_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              evout_rdy_o,
  output logic              evout_win_o,
  output logic              start_pulse_o,
  output logic              flush_pulse_o
);

  localparam int PAD_F = BUS_W - NSRC;
  localparam int PAD_E = BUS_W - NEVO;
  localparam int PAD_R = BUS_W - RES_W;

  // named internal events, also observed by the checker
  logic              wr_stb, rd_stb;
  logic              hit_flag, hit_enset, hit_enclr, hit_evcfg, hit_res;
  logic [NSRC-1:0]   flag_clr_w, en_set_w, en_clr_w;
  logic [NSRC-1:0]   flag_set_w;
  logic [NSRC-1:0]   flag_q, en_q;
  logic              rdy_evt, lost_evt, res_rd;
  logic [RES_W-1:0]  result_q;
  logic [NEVO-1:0]   evcfg_q;
  logic [1:0]        pulses;
  logic              unused_wdata;

  assign wr_stb    = bus_sel_i & bus_wr_i;
  assign rd_stb    = bus_sel_i & ~bus_wr_i;
  assign hit_flag  = bus_addr_i == ADDR_W'(REG_FLAG);
  assign hit_enset = bus_addr_i == ADDR_W'(REG_ENSET);
  assign hit_enclr = bus_addr_i == ADDR_W'(REG_ENCLR);
  assign hit_evcfg = bus_addr_i == ADDR_W'(REG_EVCFG);
  assign hit_res   = bus_addr_i == ADDR_W'(REG_RESULT);

  assign flag_clr_w = (wr_stb && hit_flag)  ? bus_wdata_i[NSRC-1:0] : '0;
  assign en_set_w   = (wr_stb && hit_enset) ? bus_wdata_i[NSRC-1:0] : '0;
  assign en_clr_w   = (wr_stb && hit_enclr) ? bus_wdata_i[NSRC-1:0] : '0;
  assign res_rd     = rd_stb & hit_res;
  assign unused_wdata = ^bus_wdata_i[BUS_W-1:NSRC];

  cvt_result_path #(.RES_W(RES_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_done_i (smp_done_i),
    .avg_done_i (avg_done_i),
    .avg_mode_i (avg_mode_i),
    .res_data_i (res_data_i),
    .res_rd_i   (res_rd),
    .rdy_evt_o  (rdy_evt),
    .lost_o     (lost_evt),
    .dma_o      (dma_req_o),
    .result_o   (result_q)
  );

  always_comb begin
    flag_set_w          = '0;
    flag_set_w[SRC_RDY] = rdy_evt;
    flag_set_w[SRC_OVR] = ovr_i | lost_evt;
    flag_set_w[SRC_WIN] = win_i;
    flag_set_w[SRC_SYN] = syn_i;
  end

  cvt_flag_bank #(.N(NSRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (flag_set_w),
    .clr_i    (flag_clr_w),
    .en_set_i (en_set_w),
    .en_clr_i (en_clr_w),
    .flag_o   (flag_q),
    .en_o     (en_q),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 evcfg_q <= '0;
    else if (wr_stb && hit_evcfg) evcfg_q <= bus_wdata_i[NEVO-1:0];
  end

  cvt_evt_gate #(.NIN(2)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .rdy_evt_i   (rdy_evt),
    .win_i       (win_i),
    .cfg_i       (evcfg_q),
    .strobe_i    ({evin_flush_i, evin_start_i}),
    .evout_rdy_o (evout_rdy_o),
    .evout_win_o (evout_win_o),
    .pulse_o     (pulses)
  );

  assign start_pulse_o = pulses[0];
  assign flush_pulse_o = pulses[1];

  always_comb begin
    bus_rdata_o = '0;
    if (rd_stb) begin
      if (hit_flag)                   bus_rdata_o = {{PAD_F{1'b0}}, flag_q};
      else if (hit_enset || hit_enclr) bus_rdata_o = {{PAD_F{1'b0}}, en_q};
      else if (hit_evcfg)             bus_rdata_o = {{PAD_E{1'b0}}, evcfg_q};
      else if (hit_res)               bus_rdata_o = {{PAD_R{1'b0}}, result_q};
    end
  end

endmodule

// File: rtl/cvt_req_chk.sv
module cvt_req_chk
  import cvt_req_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            rdy_evt,
  input logic            res_rd,
  input logic            dma_req_o,
  input logic            irq_o,
  input logic            syn_i,
  input logic            win_i,
  input logic [NSRC-1:0] flag_q,
  input logic [NSRC-1:0] flag_clr_w,
  input logic [NSRC-1:0] en_clr_w,
  input logic [NEVO-1:0] evcfg_q,
  input logic            evout_rdy_o,
  input logic            evout_win_o,
  input logic            start_pulse_o,
  input logic            flush_pulse_o
);

  a_r1_rdy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |=> flag_q[SRC_RDY]);

  a_r2_clear_syn: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_w[SRC_SYN] && !syn_i) |=> !flag_q[SRC_SYN]);

  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    syn_i |=> flag_q[SRC_SYN]);

  a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && flag_clr_w == '0 && en_clr_w == '0) |=> irq_o);

  a_r5_dma_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |=> dma_req_o);

  a_r5_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !rdy_evt) |=> !dma_req_o);

  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_evt && dma_req_o && !res_rd) |=> flag_q[SRC_OVR]);

  a_r8_rdy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    evout_rdy_o |-> (evcfg_q[EVO_RDY] && rdy_evt));

  a_r8_win_gate: assert property (@(posedge clk) disable iff (!rst_n)
    evout_win_o |-> (evcfg_q[EVO_WIN] && win_i));

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |=> !start_pulse_o);

  a_r9_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse_o |=> !flush_pulse_o);

endmodule

bind cvt_req_unit cvt_req_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rdy_evt       (rdy_evt),
  .res_rd        (res_rd),
  .dma_req_o     (dma_req_o),
  .irq_o         (irq_o),
  .syn_i         (syn_i),
  .win_i         (win_i),
  .flag_q        (flag_q),
  .flag_clr_w    (flag_clr_w),
  .en_clr_w      (en_clr_w),
  .evcfg_q       (evcfg_q),
  .evout_rdy_o   (evout_rdy_o),
  .evout_win_o   (evout_win_o),
  .start_pulse_o (start_pulse_o),
  .flush_pulse_o (flush_pulse_o)
);

// File: tb/sim_cvt_req_unit.sv
`timescale 1ns/1ps
module sim_cvt_req_unit;

  localparam int RES_W = 12;
  localparam int BUS_W = 16;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_done_i = 0, avg_done_i = 0, avg_mode_i = 0;
  logic [RES_W-1:0] res_data_i = '0;
  logic ovr_i = 0, win_i = 0, syn_i = 0, evin_start_i = 0, evin_flush_i = 0;
  logic bus_sel_i = 0, bus_wr_i = 0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [BUS_W-1:0] bus_wdata_i = '0;
  logic [BUS_W-1:0] bus_rdata_o;
  logic irq_o, dma_req_o, evout_rdy_o, evout_win_o, start_pulse_o, flush_pulse_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cvt_req_unit #(.RES_W(RES_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u0 (.*);

  // stimulus {avg_mode, smp, avg, win, syn, ovr}, expect {flags[3:0], dma, ev_rdy, ev_win}
  localparam logic [12:0] VEC [8] = '{
    {6'b010000, 4'b0001, 1'b1, 1'b1, 1'b0},
    {6'b110000, 4'b0000, 1'b0, 1'b0, 1'b0},
    {6'b101000, 4'b0001, 1'b1, 1'b1, 1'b0},
    {6'b001000, 4'b0000, 1'b0, 1'b0, 1'b0},
    {6'b000100, 4'b0100, 1'b0, 1'b0, 1'b1},
    {6'b000010, 4'b1000, 1'b0, 1'b0, 1'b0},
    {6'b000001, 4'b0010, 1'b0, 1'b0, 1'b0},
    {6'b010110, 4'b1101, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [BUS_W-1:0] d);
    bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = ADDR_W'(a); bus_wdata_i = d;
    cyc();
    bus_sel_i = 0; bus_wr_i = 0;
  endtask

  task automatic rd(input int a, output logic [BUS_W-1:0] d);
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = ADDR_W'(a);
    #1;
    d = bus_rdata_o;
    cyc();
    bus_sel_i = 0;
  endtask

  task automatic clean();
    logic [BUS_W-1:0] t;
    wr(0, 16'h000F);
    rd(4, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] d;
    repeat (3) cyc();
    // R10: reset state
    chk("R10 irq", irq_o, 0);
    chk("R10 dma", dma_req_o, 0);
    chk("R10 pulses", {start_pulse_o, flush_pulse_o, evout_rdy_o, evout_win_o}, 0);
    rst_n = 1;
    cyc();
    rd(0, d); chk("R10 flags", d, 0);
    rd(1, d); chk("R10 enables", d, 0);
    rd(3, d); chk("R10 evcfg", d, 0);

    // table walk: R1 R6 R7 R8
    wr(3, 16'h0003);
    rd(3, d); chk("R8 evcfg readback", d, 3);
    for (int i = 0; i < 8; i++) begin
      {avg_mode_i, smp_done_i, avg_done_i, win_i, syn_i, ovr_i} = VEC[i][12:7];
      #1;
      chk($sformatf("R8 vec%0d events", i), {evout_rdy_o, evout_win_o}, VEC[i][1:0]);
      cyc();
      {smp_done_i, avg_done_i, win_i, syn_i, ovr_i} = '0;
      chk($sformatf("R5 R6 vec%0d dma", i), dma_req_o, VEC[i][2]);
      rd(0, d);
      chk($sformatf("R1 R6 vec%0d flags", i), d, {12'h0, VEC[i][6:3]});
      avg_mode_i = 0;
      clean();
    end

    // R3: enable set / clear
    wr(1, 16'h0005);
    rd(1, d); chk("R3 set", d, 5);
    rd(2, d); chk("R3 clear-addr readback", d, 5);
    wr(1, 16'h0000);
    rd(1, d); chk("R3 zero set no effect", d, 5);
    wr(2, 16'h0001);
    rd(1, d); chk("R3 clear", d, 4);
    wr(2, 16'h0000);
    rd(2, d); chk("R3 zero clear no effect", d, 4);

    // R4: interrupt
    chk("R4 idle", irq_o, 0);
    win_i = 1; cyc(); win_i = 0;
    chk("R4 enabled flag", irq_o, 1);
    syn_i = 1; cyc(); syn_i = 0;
    wr(0, 16'h0004);
    chk("R4 disabled flag only", irq_o, 0);
    wr(1, 16'h0008);
    chk("R4 enable pending", irq_o, 1);
    wr(2, 16'h0008);
    chk("R4 disable", irq_o, 0);

    // R2: zero write and set-wins
    wr(0, 16'h0000);
    rd(0, d); chk("R2 zero write", d, 8);
    wr(0, 16'h0008);
    rd(0, d); chk("R2 clear", d, 0);
    syn_i = 1; bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 0; bus_wdata_i = 16'h0008;
    cyc();
    syn_i = 0; bus_sel_i = 0; bus_wr_i = 0;
    rd(0, d); chk("R2 set wins", d, 8);
    clean();

    // R5 / R7: result path
    res_data_i = 12'h0AA; smp_done_i = 1; cyc(); smp_done_i = 0;
    chk("R5 dma up", dma_req_o, 1);
    smp_done_i = 1; res_data_i = 12'h0BB;
    bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = 3'd4;
    #1; chk("R5 read old during new", bus_rdata_o, 16'h00AA);
    cyc();
    smp_done_i = 0; bus_sel_i = 0;
    chk("R5 dma kept", dma_req_o, 1);
    rd(0, d); chk("R7 no overrun on read", d[1], 0);
    smp_done_i = 1; res_data_i = 12'h0CC; cyc(); smp_done_i = 0;
    rd(0, d); chk("R7 overrun", d[1], 1);
    rd(4, d); chk("R5 result", d, 16'h00CC);
    chk("R5 dma drop", dma_req_o, 0);
    clean();

    // R8: gated off
    wr(3, 16'h0000);
    smp_done_i = 1; win_i = 1; #1;
    chk("R8 gated off", {evout_rdy_o, evout_win_o}, 0);
    cyc(); smp_done_i = 0; win_i = 0;
    clean();
    wr(2, 16'h000F);

    // R9: incoming strobes
    evin_start_i = 1; #1;
    chk("R9 no early start", start_pulse_o, 0);
    cyc(); chk("R9 start pulse", start_pulse_o, 1);
    cyc(); chk("R9 start single", start_pulse_o, 0);
    evin_start_i = 0;
    evin_flush_i = 1; cyc();
    chk("R9 flush pulse", flush_pulse_o, 1);
    cyc(); chk("R9 flush single", flush_pulse_o, 0);
    evin_flush_i = 0;
    rd(0, d); chk("R9 no flags", d, 0);
    chk("R9 no dma irq", {dma_req_o, irq_o}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule